// File: doc/BRIEF.md
# Programmable Address Aperture Decoder

This block sits where a 32-bit request stream fans out to memory, the on-chip register space and an external expansion bus. Each accepted request, with its address, direction and write data, is checked against a set of programmable windows. It is then forwarded one cycle later with a one-hot target strobe. The three targets are the DRAM controller, the register (MMIO) space and the single external-bus module. For the external bus, a second one-hot vector names which of its three windows was hit.

The MMIO window is a fixed 2 MiB span at a programmable base. It is live from reset. Every other window is a pair of programmable bounds and matches when low <= address < high. A high bound of zero stands for the very top of the 4 GiB space. Requests that come from the CPU side are marked. Such a request reaches an external window only if it also falls inside a separate CPU-side general window. A request that hits nothing is absorbed locally and never faults: a write is dropped, and a read gets a filler word.

Bounds are written through a small indexed write port. A write becomes visible to decoding on the cycle after it is accepted.

Top module: `aperture_router`

## Requirements
- R1: After reset, no strobe or response is asserted. The DRAM, external and CPU-side general windows are empty (low equal to high, both 0x0000_1000), so only the MMIO window decodes.
- R2: A bounded window matches an address exactly when low <= address < effective high. The address equal to high does not match.
- R3: A high bound of 0x0000_0000 is taken as 0x1_0000_0000, so the window covers the address 0xFFFF_FFFC.
- R4: The MMIO window covers base <= address < base + 0x20_0000. Its base resets to 0x1BE0_0000.
- R5: Overlapping windows resolve in this fixed order: MMIO first, then DRAM, then PCI1, then PCI2, then XIO.
- R6: The target strobe `out_tgt` has bit 0 for MMIO, bit 1 for DRAM and bit 2 for the external bus. The window vector `out_win` has bit 0 for MMIO, bit 1 for DRAM, bit 2 for PCI1, bit 3 for PCI2 and bit 4 for XIO. Every external window hit raises `out_tgt[2]`.
- R7: A request with `req_cpu` high hits an external window only if its address also lies in the CPU-side general window. Otherwise it is unmatched. MMIO and DRAM decoding ignore `req_cpu`.
- R8: An unmatched request raises no strobe. It raises `rsp_valid` one cycle later. `rsp_rdata` is 0xDEAD_BEEF for a read and zero for a write.
- R9: Strobes and the forwarded address, direction and data appear on the cycle after the request. At most one window bit is set, and with no request nothing is asserted.
- R10: A bound write at `cfg_idx` takes effect for requests from the next cycle on. The index map is: 0 MMIO base; 1 and 2 DRAM low and high; 3 and 4 PCI1; 5 and 6 PCI2; 7 and 8 XIO; 9 and 10 the CPU-side general window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Bound register write enable |
| cfg_idx | input | 4 | Bound register index |
| cfg_wdata | input | 32 | Bound register write value |
| req_valid | input | 1 | Request present this cycle |
| req_cpu | input | 1 | Request comes from the CPU side |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Request write data |
| out_tgt | output | 3 | One-hot target strobe (MMIO, DRAM, external) |
| out_win | output | 5 | One-hot window that was hit |
| out_addr | output | 32 | Forwarded address |
| out_we | output | 1 | Forwarded direction |
| out_wdata | output | 32 | Forwarded write data |
| rsp_valid | output | 1 | Local completion for an unmatched request |
| rsp_rdata | output | 32 | Local read data |

## Verification
Addresses are placed on both sides of each bound: the last word inside and the high bound itself. This separates an inclusive comparison from an exclusive one. An XIO window with a zero high bound is probed at the last word of the space. Deliberately overlapping DRAM, PCI and MMIO ranges expose any error in the priority order. The same PCI address is issued with and without the CPU-side flag, before and after the general window is opened, to show the gating. A bound write issued in the same cycle as a request to the newly covered address shows whether the update is visible early. Unmatched reads and writes check the filler value against zero.

// File: rtl/aperture_router.sv
module aperture_router #(
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter logic [31:0] MMIO_SPAN   = 32'h0020_0000,
  parameter logic [31:0] MMIO_RESET  = 32'h1BE0_0000,
  parameter logic [31:0] EMPTY_BOUND = 32'h0000_1000,
  parameter logic [31:0] FILL        = 32'hDEAD_BEEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_idx,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic          req_cpu,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [2:0]    out_tgt,
  output logic [4:0]    out_win,
  output logic [AW-1:0] out_addr,
  output logic          out_we,
  output logic [DW-1:0] out_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  localparam int NWIN = 5;          // DRAM, PCI1, PCI2, XIO, CPU general
  localparam int GEN  = NWIN - 1;
  localparam logic [AW:0] TOP = {1'b1, {AW{1'b0}}};

  logic [AW-1:0] mmio_base;
  logic [NWIN-1:0] hit;
  logic [AW:0] a_ext;
  logic mmio_hit, ext_ok;
  logic [4:0] win_nx;

  assign a_ext = {1'b0, req_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) mmio_base <= MMIO_RESET[AW-1:0];
    else if (cfg_we && cfg_idx == 4'd0) mmio_base <= cfg_wdata;
  end

  assign mmio_hit = (a_ext >= {1'b0, mmio_base}) &&
                    (a_ext < ({1'b0, mmio_base} + {1'b0, MMIO_SPAN[AW-1:0]}));

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    localparam logic [3:0] LO_IDX = 4'(1 + 2*k);
    localparam logic [3:0] HI_IDX = 4'(2 + 2*k);
    logic [AW-1:0] lo, hi;
    logic [AW:0] hi_eff;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo <= EMPTY_BOUND[AW-1:0];
        hi <= EMPTY_BOUND[AW-1:0];
      end else if (cfg_we) begin
        if (cfg_idx == LO_IDX) lo <= cfg_wdata;
        if (cfg_idx == HI_IDX) hi <= cfg_wdata;
      end
    end

    assign hi_eff = (hi == '0) ? TOP : {1'b0, hi};
    assign hit[k] = (a_ext >= {1'b0, lo}) && (a_ext < hi_eff);
  end

  assign ext_ok = !req_cpu || hit[GEN];

  always_comb begin
    win_nx = '0;
    if (mmio_hit)             win_nx[0] = 1'b1;
    else if (hit[0])          win_nx[1] = 1'b1;
    else if (hit[1] && ext_ok) win_nx[2] = 1'b1;
    else if (hit[2] && ext_ok) win_nx[3] = 1'b1;
    else if (hit[3] && ext_ok) win_nx[4] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_win   <= '0;
      out_addr  <= '0;
      out_we    <= 1'b0;
      out_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      out_win   <= req_valid ? win_nx : '0;
      rsp_valid <= req_valid && (win_nx == '0);
      rsp_rdata <= (req_valid && win_nx == '0 && !req_we) ? FILL[DW-1:0] : '0;
      if (req_valid) begin
        out_addr  <= req_addr;
        out_we    <= req_we;
        out_wdata <= req_wdata;
      end
    end
  end

  assign out_tgt = {|out_win[4:2], out_win[1], out_win[0]};
endmodule

// File: rtl/aperture_router_chk.sv
module aperture_router_chk #(
  parameter int          AW   = 32,
  parameter int          DW   = 32,
  parameter logic [31:0] FILL = 32'hDEAD_BEEF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_we,
  input logic [AW-1:0] req_addr,
  input logic [4:0]    out_win,
  input logic [AW-1:0] out_addr,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata
);
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_win));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (out_win == '0 && !rsp_valid));

  p_payload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_win == '0 || out_addr == $past(req_addr)));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> out_win == '0);

  p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> (!rsp_valid || rsp_rdata == FILL[DW-1:0]));

  p_wzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> rsp_rdata == '0);
endmodule

bind aperture_router aperture_router_chk #(.AW(AW), .DW(DW), .FILL(FILL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .out_win(out_win), .out_addr(out_addr),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
);

// File: tb/test_aperture_router.sv
module test_aperture_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_cpu = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0] out_tgt;
  logic [4:0] out_win;
  logic [31:0] out_addr, out_wdata, rsp_rdata;
  logic out_we, rsp_valid;

  int tests = 0, fails = 0;
  bit done = 0;
  longint mdl[11];

  always #4 clk = ~clk;

  aperture_router i_aperture_router (.*);

  function automatic bit inwin(int lo_idx, longint x);
    longint h = (mdl[lo_idx+1] == 0) ? 64'h1_0000_0000 : mdl[lo_idx+1];
    return x >= mdl[lo_idx] && x < h;
  endfunction

  function automatic int route(bit cpu, logic [31:0] a);
    longint x = {32'h0, a};
    bit gen = inwin(9, x);
    if (x >= mdl[0] && x < mdl[0] + 64'h20_0000) return 0;
    if (inwin(1, x)) return 1;
    for (int w = 2; w <= 4; w++)
      if (inwin(2*w-1, x) && (!cpu || gen)) return w;
    return -1;
  endfunction

  function automatic void mdl_reset();
    mdl[0] = 64'h1BE0_0000;
    for (int i = 1; i < 11; i++) mdl[i] = 64'h1000;
  endfunction

  task automatic step(bit v, bit cpu, bit we, logic [31:0] a, logic [31:0] d,
                      bit cw, int ci, logic [31:0] cd, string tag);
    int r;
    logic [4:0] ew;
    logic [2:0] et;
    bit er;
    logic [31:0] ed;
    req_valid = v; req_cpu = cpu; req_we = we; req_addr = a; req_wdata = d;
    cfg_we = cw; cfg_idx = 4'(ci); cfg_wdata = cd;
    r  = v ? route(cpu, a) : -2;
    ew = (r >= 0) ? 5'(1 << r) : 5'b0;
    et = (r < 0) ? 3'b000 : (r == 0) ? 3'b001 : (r == 1) ? 3'b010 : 3'b100;
    er = (r == -1);
    ed = (er && !we) ? 32'hDEAD_BEEF : 32'h0;
    @(posedge clk);
    if (cw) mdl[ci] = {32'h0, cd};
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    tests++;
    if (out_win !== ew || out_tgt !== et || rsp_valid !== er || rsp_rdata !== ed ||
        (r >= 0 && (out_addr !== a || out_we !== we || out_wdata !== d))) begin
      fails++;
      $display("FAIL %s addr=%h: win=%b tgt=%b rsp=%b rd=%h oaddr=%h owe=%b od=%h exp win=%b tgt=%b rsp=%b rd=%h",
               tag, a, out_win, out_tgt, rsp_valid, rsp_rdata, out_addr, out_we, out_wdata,
               ew, et, er, ed);
    end
  endtask

  task automatic wcfg(int ci, logic [31:0] cd);
    step(0, 0, 0, 0, 0, 1, ci, cd, "R10 cfg");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mdl_reset();
    repeat (3) @(negedge clk);
    tests++;
    if (out_tgt !== 0 || out_win !== 0 || rsp_valid !== 0) begin
      fails++;
      $display("FAIL R1 reset: tgt=%b win=%b rsp=%b exp 0 0 0", out_tgt, out_win, rsp_valid);
    end
    rst_n = 1;
    step(1, 0, 0, 32'h0000_1000, 0, 0, 0, 0, "R1 empty dram");
    step(1, 0, 0, 32'h1BE0_0000, 0, 0, 0, 0, "R4 mmio base");
    step(1, 0, 1, 32'h1BFF_FFFC, 32'h1234_5678, 0, 0, 0, "R4 mmio top");
    step(1, 0, 1, 32'h1C00_0000, 32'h5, 0, 0, 0, "R4 past mmio, R8 write");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
    // DRAM bounds; request in same cycle as write sees old bound
    wcfg(1, 32'h0);
    step(1, 0, 0, 32'h0800_0000, 0, 1, 2, 32'h1000_0000, "R10 old bound");
    step(1, 0, 0, 32'h0800_0000, 0, 0, 0, 0, "R10 new bound");
    step(1, 0, 1, 32'h0FFF_FFFC, 32'hA5A5_A5A5, 0, 0, 0, "R2 dram last");
    step(1, 0, 0, 32'h1000_0000, 0, 0, 0, 0, "R2 dram hi excl");
    // external windows
    wcfg(3, 32'h2000_0000); wcfg(4, 32'h3000_0000);
    wcfg(5, 32'h3000_0000); wcfg(6, 32'h4000_0000);
    wcfg(7, 32'hF000_0000); wcfg(8, 32'h0);
    step(1, 0, 0, 32'h2FFF_FFFC, 0, 0, 0, 0, "R6 pci1");
    step(1, 0, 1, 32'h3000_0000, 32'h77, 0, 0, 0, "R6 pci2");
    step(1, 0, 0, 32'hFFFF_FFFC, 0, 0, 0, 0, "R3 xio top");
    step(1, 0, 0, 32'hEFFF_FFFC, 0, 0, 0, 0, "R2 xio below");
    // CPU-side gating
    step(1, 1, 0, 32'h2000_0000, 0, 0, 0, 0, "R7 gen closed");
    step(1, 1, 0, 32'h0000_0010, 0, 0, 0, 0, "R7 dram not gated");
    step(1, 1, 0, 32'h1BE0_0004, 0, 0, 0, 0, "R7 mmio not gated");
    wcfg(9, 32'h2000_0000); wcfg(10, 32'h4000_0000);
    step(1, 1, 0, 32'h2000_0000, 0, 0, 0, 0, "R7 gen open pci1");
    step(1, 1, 1, 32'h3FFF_FFFC, 32'h9, 0, 0, 0, "R7 gen open pci2");
    step(1, 1, 0, 32'hF000_0000, 0, 0, 0, 0, "R7 xio outside gen");
    step(1, 0, 0, 32'hF000_0000, 0, 0, 0, 0, "R7 xio non-cpu");
    // overlaps
    wcfg(2, 32'h0);
    step(1, 0, 0, 32'h1BE0_0100, 0, 0, 0, 0, "R5 mmio over dram");
    step(1, 0, 0, 32'h2000_0000, 0, 0, 0, 0, "R5 dram over pci1");
    wcfg(2, 32'h1000_0000);
    wcfg(4, 32'h3800_0000);
    step(1, 0, 0, 32'h3400_0000, 0, 0, 0, 0, "R5 pci1 over pci2");
    wcfg(7, 32'h3000_0000);
    step(1, 0, 0, 32'h3C00_0000, 0, 0, 0, 0, "R5 pci2 over xio");
    wcfg(0, 32'h3C00_0000);
    step(1, 0, 0, 32'h3C00_0000, 0, 0, 0, 0, "R5 R4 moved mmio");
    step(1, 0, 0, 32'h1BE0_0000, 0, 0, 0, 0, "R4 old mmio base");
    step(1, 0, 0, 32'h1200_0000, 0, 0, 0, 0, "R8 read fill");
    step(1, 0, 1, 32'h1200_0000, 32'hFFFF, 0, 0, 0, "R8 write drop");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 idle end");
    finish_run();
  end
endmodule